// File: doc/BRIEF.md
# Power Mode and Bus-Master Clock-Rate Controller

This controller decides which operating mode a microcontroller core is in and how fast its bus masters run. Software writes a three-bit divisor field. A nonzero value slows the bus masters to the system clock divided by 2, 4, 8, 16 or 32. Zero gives full-speed operation. A new divisor is held back until the current bus cycle reports its end, so an access never changes speed partway through. The peripherals keep running on every system clock while the bus masters are slowed.

A SLEEP request moves the core into a low-power state chosen by three control inputs: standby, low-speed and watchdog prescaler select. In light sleep the bus masters stop and the peripherals keep running, and any interrupt wakes the core. In software standby both clock gates close, and only an external interrupt wakes the core. After either wake-up the core returns to the run mode given by the divisor in effect, which is medium speed when that divisor is nonzero. Driving the reset pin low, or a watchdog overflow, puts the controller in the reset state from any mode.

The bus-master enable is a one-cycle pulse taken from a free-running prescaler. The prescaler restarts whenever a different divisor takes effect.

Top module: `pwr_clk_ctl`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (reset), and `bm_clk_en` and `per_clk_en` are 0. The first clock edge after release gives `mode_o` = 1 (high speed), and in that mode `bm_clk_en` is 1 on every cycle. The mode codes are: 0 reset, 1 high speed, 2 medium speed, 3 sleep, 4 software standby.
- R2: A divisor written through `sel_wr`/`sel_wdata` takes effect only at a clock edge where `bus_end` is 1 while the core is in a run mode (1 or 2). Until then the previous divisor and mode stay in force. A `bus_end` pulse during sleep or standby applies nothing.
- R3: With divisor code k in 1..5, `bm_clk_en` is a one-cycle pulse once every 2^k cycles. Codes 6 and 7 act as code 5. The first pulse is high in the cycle that starts 2^k−1 edges after the edge where the divisor took effect, so the first period is never short.
- R4: Writing 000 and then ending a bus cycle returns the core from mode 2 to mode 1, with `bm_clk_en` continuously 1. No change happens before that `bus_end`.
- R5: `per_clk_en` is 1 in modes 1, 2 and 3.
- R6: A `sleep_req` in a run mode with `stby_bit`=0 and `lowspd_bit`=0 gives mode 3 at the next edge. In mode 3, `bm_clk_en`=0 and `per_clk_en`=1.
- R7: In mode 3, `irq_any` or `irq_ext` returns the core to the run mode set by the active divisor: 2 when it is nonzero, 1 when it is 000. Interrupts in a run mode change nothing.
- R8: A `sleep_req` in a run mode with `stby_bit`=1, `lowspd_bit`=0 and `wdt_pss`=0 gives mode 4. In mode 4 both `bm_clk_en` and `per_clk_en` are 0.
- R9: In mode 4, `irq_any` alone has no effect. Only `irq_ext` returns the core to the run mode set by the active divisor.
- R10: A `sleep_req` with any other combination of control bits is ignored, and so is a `sleep_req` while already in mode 3 or 4. The mode is unchanged.
- R11: `wdt_ovf` gives mode 0 at the next edge from any mode, with both gates 0, and clears the divisor (both the written value and the active value) to 000. The following edge gives mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset pin |
| wdt_ovf | input | 1 | Watchdog overflow, forces reset state |
| sel_wr | input | 1 | Write strobe for the divisor field |
| sel_wdata | input | SEL_W | Divisor code to write |
| bus_end | input | 1 | Current bus cycle completes this cycle |
| sleep_req | input | 1 | SLEEP instruction executed |
| stby_bit | input | 1 | Standby control bit |
| lowspd_bit | input | 1 | Low-speed control bit |
| wdt_pss | input | 1 | Watchdog prescaler-select bit |
| irq_any | input | 1 | Any interrupt pending |
| irq_ext | input | 1 | External interrupt pending |
| mode_o | output | 3 | Current mode code |
| bm_clk_en | output | 1 | Bus-master clock enable |
| per_clk_en | output | 1 | Peripheral clock gate |

## Verification
Each mode change appears on `mode_o` one edge after the input that causes it: a sleep request, an interrupt, a watchdog overflow, or a `bus_end` that applies a written divisor. The gates follow from the registered state with no further delay. The exception is the reset pin, which acts at once. After the edge that applies a divisor, `bm_clk_en` is first high 2^k−1 edges later and then every 2^k edges. The bench therefore indexes samples from that edge. It drives inputs and samples outputs 1 ns after each rising edge, and it compares each sample with the value expected for that cycle.

// File: rtl/pwr_clk_pkg.sv
`timescale 1ns/1ps
package pwr_clk_pkg;

   typedef enum logic [2:0] {
      MODE_RESET = 3'd0,
      MODE_HIGH  = 3'd1,
      MODE_MED   = 3'd2,
      MODE_SLEEP = 3'd3,
      MODE_STBY  = 3'd4
   } pmode_e;

   typedef enum logic [1:0] {
      ST_RST = 2'd0,
      ST_RUN = 2'd1,
      ST_SLP = 2'd2,
      ST_STB = 2'd3
   } pstate_e;

endpackage

// File: rtl/pwr_sel_reg.sv
`timescale 1ns/1ps
// Written and active divisor codes; the active code updates only on apply.
module pwr_sel_reg #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr,
   input  logic [SEL_W-1:0] wdata,
   input  logic             apply,
   output logic [SEL_W-1:0] active,
   output logic             restart
);
   logic [SEL_W-1:0] pend_q;
   logic [SEL_W-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         act_q  <= '0;
      end else if (clr) begin
         pend_q <= '0;
         act_q  <= '0;
      end else begin
         if (wr)    pend_q <= wdata;
         if (apply) act_q  <= pend_q;
      end
   end

   assign active  = act_q;
   assign restart = apply && (pend_q != act_q);
endmodule

// File: rtl/pwr_prescaler.sv
`timescale 1ns/1ps
// Free-running prescaler with one tick tap per power-of-two divisor.
module pwr_prescaler #(
   parameter int PRE_W = 5,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [SEL_W-1:0] div_sel,
   output logic             tick
);
   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W:0]   tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else              cnt_q <= cnt_q + PRE_W'(1);
   end

   assign tap[0] = 1'b1;
   for (genvar k = 1; k <= PRE_W; k++) begin : g_tap
      assign tap[k] = &cnt_q[k-1:0];
   end

   // codes above PRE_W saturate to the slowest tap
   always_comb begin
      tick = tap[PRE_W];
      for (int k = 0; k <= PRE_W; k++) begin
         if (int'(div_sel) == k) tick = tap[k];
      end
   end
endmodule

// File: rtl/pwr_mode_fsm.sv
`timescale 1ns/1ps
// Operating-state sequencer: reset, run, sleep, standby.
module pwr_mode_fsm
   import pwr_clk_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wdt_ovf,
   input  logic    sleep_req,
   input  logic    stby_bit,
   input  logic    lowspd_bit,
   input  logic    wdt_pss,
   input  logic    irq_any,
   input  logic    irq_ext,
   output pstate_e state
);
   pstate_e st_q, st_d;
   logic    go_sleep, go_stby;

   assign go_sleep = sleep_req && !stby_bit && !lowspd_bit;
   assign go_stby  = sleep_req &&  stby_bit && !lowspd_bit && !wdt_pss;

   always_comb begin
      st_d = st_q;
      if (wdt_ovf) begin
         st_d = ST_RST;
      end else begin
         case (st_q)
            ST_RST:  st_d = ST_RUN;
            ST_RUN: begin
               if (go_sleep)     st_d = ST_SLP;
               else if (go_stby) st_d = ST_STB;
            end
            ST_SLP:  if (irq_any || irq_ext) st_d = ST_RUN;
            ST_STB:  if (irq_ext)            st_d = ST_RUN;
            default: st_d = ST_RST;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_RST;
      else        st_q <= st_d;
   end

   assign state = st_q;
endmodule

// File: rtl/pwr_clk_ctl.sv
`timescale 1ns/1ps
module pwr_clk_ctl
   import pwr_clk_pkg::*;
#(
   parameter int PRE_W = 5,
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_ovf,
   input  logic             sel_wr,
   input  logic [SEL_W-1:0] sel_wdata,
   input  logic             bus_end,
   input  logic             sleep_req,
   input  logic             stby_bit,
   input  logic             lowspd_bit,
   input  logic             wdt_pss,
   input  logic             irq_any,
   input  logic             irq_ext,
   output logic [2:0]       mode_o,
   output logic             bm_clk_en,
   output logic             per_clk_en
);
   localparam int MAX_CODE = (1 << SEL_W) - 1;

   if (PRE_W < 1) begin : g_bad_pre
      $error("pwr_clk_ctl: PRE_W must be at least 1");
   end
   if (MAX_CODE < PRE_W) begin : g_bad_sel
      $error("pwr_clk_ctl: SEL_W too narrow to code every divisor");
   end

   pstate_e          state;
   logic [SEL_W-1:0] active_sel;
   logic             restart;
   logic             tick;
   logic             in_run;
   pmode_e           mode_v;

   assign in_run = (state == ST_RUN);

   pwr_mode_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wdt_ovf    (wdt_ovf),
      .sleep_req  (sleep_req),
      .stby_bit   (stby_bit),
      .lowspd_bit (lowspd_bit),
      .wdt_pss    (wdt_pss),
      .irq_any    (irq_any),
      .irq_ext    (irq_ext),
      .state      (state)
   );

   pwr_sel_reg #(.SEL_W(SEL_W)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (wdt_ovf),
      .wr      (sel_wr),
      .wdata   (sel_wdata),
      .apply   (bus_end && in_run),
      .active  (active_sel),
      .restart (restart)
   );

   pwr_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .div_sel (active_sel),
      .tick    (tick)
   );

   always_comb begin
      case (state)
         ST_RUN:  mode_v = (active_sel != '0) ? MODE_MED : MODE_HIGH;
         ST_SLP:  mode_v = MODE_SLEEP;
         ST_STB:  mode_v = MODE_STBY;
         default: mode_v = MODE_RESET;
      endcase
   end

   assign mode_o     = mode_v;
   assign bm_clk_en  = in_run && tick;
   assign per_clk_en = in_run || (state == ST_SLP);
endmodule

// File: rtl/pwr_clk_ctl_chk.sv
`timescale 1ns/1ps
module pwr_clk_ctl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       wdt_ovf,
   input logic       bus_end,
   input logic       sleep_req,
   input logic       irq_ext,
   input logic [2:0] mode_o,
   input logic       bm_clk_en,
   input logic       per_clk_en
);
   AST_HIGH_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1) |-> bm_clk_en); // R1

   AST_HOLD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1 && !bus_end && !wdt_ovf && !sleep_req) |=> (mode_o == 3'd1)); // R2

   AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && bm_clk_en) |=> (mode_o != 3'd2 || !bm_clk_en)); // R3

   AST_RUN_PER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd1 || mode_o == 3'd2) |-> per_clk_en); // R5

   AST_SLEEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3) |-> (!bm_clk_en && per_clk_en)); // R6

   AST_STBY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4) |-> (!bm_clk_en && !per_clk_en)); // R8

   AST_STBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4 && !irq_ext && !wdt_ovf) |=> (mode_o == 3'd4)); // R9

   AST_WDT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_ovf |=> (mode_o == 3'd0 && !bm_clk_en && !per_clk_en)); // R11
endmodule

bind pwr_clk_ctl pwr_clk_ctl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wdt_ovf    (wdt_ovf),
   .bus_end    (bus_end),
   .sleep_req  (sleep_req),
   .irq_ext    (irq_ext),
   .mode_o     (mode_o),
   .bm_clk_en  (bm_clk_en),
   .per_clk_en (per_clk_en)
);

// File: tb/pwr_clk_ctl_bench.sv
`timescale 1ns/1ps
module pwr_clk_ctl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wdt_ovf = 1'b0;
   logic       sel_wr = 1'b0;
   logic [2:0] sel_wdata = '0;
   logic       bus_end = 1'b0;
   logic       sleep_req = 1'b0;
   logic       stby_bit = 1'b0;
   logic       lowspd_bit = 1'b0;
   logic       wdt_pss = 1'b0;
   logic       irq_any = 1'b0;
   logic       irq_ext = 1'b0;
   logic [2:0] mode_o;
   logic       bm_clk_en;
   logic       per_clk_en;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pwr_clk_ctl u_pwr_clk_ctl (
      .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .sel_wr(sel_wr),
      .sel_wdata(sel_wdata), .bus_end(bus_end), .sleep_req(sleep_req),
      .stby_bit(stby_bit), .lowspd_bit(lowspd_bit), .wdt_pss(wdt_pss),
      .irq_any(irq_any), .irq_ext(irq_ext), .mode_o(mode_o),
      .bm_clk_en(bm_clk_en), .per_clk_en(per_clk_en)
   );

   // {req, sleep, stby, lowspd, pss, irq_any, irq_ext, mode, bm_en, per_en}
   localparam int NV = 14;
   localparam logic [14:0] VEC [NV] = '{
      {4'd6,  6'b100000, 3'd3, 1'b0, 1'b1},  // R6 light sleep
      {4'd7,  6'b000010, 3'd1, 1'b1, 1'b1},  // R7 any irq wakes
      {4'd8,  6'b110000, 3'd4, 1'b0, 1'b0},  // R8 standby
      {4'd9,  6'b000010, 3'd4, 1'b0, 1'b0},  // R9 internal irq ignored
      {4'd9,  6'b000001, 3'd1, 1'b1, 1'b1},  // R9 external irq wakes
      {4'd10, 6'b101000, 3'd1, 1'b1, 1'b1},  // R10 low-speed set
      {4'd10, 6'b110100, 3'd1, 1'b1, 1'b1},  // R10 pss set
      {4'd10, 6'b111000, 3'd1, 1'b1, 1'b1},  // R10 both set
      {4'd7,  6'b000011, 3'd1, 1'b1, 1'b1},  // R7 irq in run no effect
      {4'd6,  6'b100000, 3'd3, 1'b0, 1'b1},  // R6
      {4'd7,  6'b000001, 3'd1, 1'b1, 1'b1},  // R7 ext irq wakes sleep
      {4'd6,  6'b100000, 3'd3, 1'b0, 1'b1},  // R6
      {4'd10, 6'b110000, 3'd3, 1'b0, 1'b1},  // R10 sleep while sleeping
      {4'd7,  6'b000010, 3'd1, 1'b1, 1'b1}   // R7
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_out(input string req, input int m, input int bm, input int pe);
      chk(req, "mode", int'(mode_o), m);
      chk(req, "bm_en", int'(bm_clk_en), bm);
      chk(req, "per_en", int'(per_clk_en), pe);
   endtask

   task automatic write_sel(input logic [2:0] v);
      sel_wr = 1'b1; sel_wdata = v;
      step();
      sel_wr = 1'b0;
   endtask

   task automatic end_bus();
      bus_end = 1'b1;
      step();
      bus_end = 1'b0;
   endtask

   task automatic do_sleep(input logic sb, input logic lo, input logic ps);
      sleep_req = 1'b1; stby_bit = sb; lowspd_bit = lo; wdt_pss = ps;
      step();
      sleep_req = 1'b0; stby_bit = 1'b0; lowspd_bit = 1'b0; wdt_pss = 1'b0;
   endtask

   task automatic pulse_pattern(input string req, input int period, input int len);
      for (int j = 0; j < len; j++) begin
         chk(req, "bm_en pattern", int'(bm_clk_en), ((j % period) == period - 1) ? 1 : 0);
         step();
      end
   endtask

   initial begin
      int first;
      int cnt;
      step(); step();
      chk_out("R1", 0, 0, 0);                 // held in reset
      rst_n = 1'b1;
      step();
      chk_out("R1", 1, 1, 1);
      step();
      chk_out("R1", 1, 1, 1);

      for (int i = 0; i < NV; i++) begin
         logic [14:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d", v[14:11]);
         {sleep_req, stby_bit, lowspd_bit, wdt_pss, irq_any, irq_ext} = v[10:5];
         step();
         {sleep_req, stby_bit, lowspd_bit, wdt_pss, irq_any, irq_ext} = '0;
         chk_out(tag, int'(v[4:2]), int'(v[1]), int'(v[0]));
      end

      // R2: written divisor waits for bus_end
      write_sel(3'd2);
      chk_out("R2", 1, 1, 1);
      repeat (3) begin step(); chk_out("R2", 1, 1, 1); end
      end_bus();
      chk("R2", "mode after bus_end", int'(mode_o), 2);
      chk("R5", "per_en medium", int'(per_clk_en), 1);
      pulse_pattern("R3", 4, 12);

      write_sel(3'd1);
      end_bus();
      pulse_pattern("R3", 2, 8);

      for (int s = 5; s <= 7; s += 2) begin   // code 5 and saturating code 7
         write_sel(3'(s));
         if (s == 7) write_sel(3'd1);          // force a real change first
         if (s == 7) begin end_bus(); write_sel(3'd7); end
         end_bus();
         first = -1; cnt = 0;
         for (int j = 0; j < 64; j++) begin
            if (bm_clk_en) begin
               cnt++;
               if (first < 0) first = j;
            end
            step();
         end
         chk("R3", "first pulse /32", first, 31);
         chk("R3", "pulses in 64", cnt, 2);
      end

      // R6/R7 from medium, R2 bus_end ignored while asleep
      do_sleep(1'b0, 1'b0, 1'b0);
      chk_out("R6", 3, 0, 1);
      repeat (4) begin step(); chk_out("R6", 3, 0, 1); end
      write_sel(3'd0);
      end_bus();
      chk_out("R2", 3, 0, 1);
      irq_any = 1'b1; step(); irq_any = 1'b0;
      chk("R7", "wake to medium", int'(mode_o), 2);
      step();
      chk("R4", "no change before bus_end", int'(mode_o), 2);
      end_bus();
      chk_out("R4", 1, 1, 1);
      repeat (3) begin step(); chk_out("R4", 1, 1, 1); end

      // standby from medium
      write_sel(3'd3);
      end_bus();
      chk("R2", "mode /8", int'(mode_o), 2);
      do_sleep(1'b1, 1'b0, 1'b0);
      chk_out("R8", 4, 0, 0);
      irq_any = 1'b1; step(); irq_any = 1'b0;
      chk_out("R9", 4, 0, 0);
      irq_ext = 1'b1; step(); irq_ext = 1'b0;
      chk("R9", "ext wake to medium", int'(mode_o), 2);

      // watchdog overflow
      wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
      chk_out("R11", 0, 0, 0);
      step();
      chk_out("R11", 1, 1, 1);
      end_bus();
      chk("R11", "divisor cleared", int'(mode_o), 1);
      do_sleep(1'b1, 1'b0, 1'b0);
      chk("R11", "standby before wdt", int'(mode_o), 4);
      wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
      chk_out("R11", 0, 0, 0);
      step();
      chk("R11", "run after wdt", int'(mode_o), 1);

      // reset pin mid-run acts at once
      write_sel(3'd2);
      end_bus();
      chk("R1", "medium before reset", int'(mode_o), 2);
      rst_n = 1'b0;
      #1;
      chk_out("R1", 0, 0, 0);
      rst_n = 1'b1;
      step();
      chk_out("R1", 1, 1, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule